// File: doc/BRIEF.md
# Paired set/clear GPIO bank

This block is a small bank of general-purpose I/O pins driven through a single 32-bit command word. Every pin owns four command bits. One lowers its output level, one raises it, one turns the output driver on and one turns it off. A write acts only on the bits that are 1, so two agents sharing the bank never need to read the word back before they update their own pins. They need no lock either.

A read of the same word returns each pin's level at its odd data position. For a pin that is driving, that level is the value it drives. For any other pin, it is the pad level after a two-stage synchronizer. All other read bits are zero.

The pin count defaults to 8 and may be reduced. A 4-pin build is the second supported size, and it ignores command bits that belong to pins it does not have.

Top module: `sc_gpio_bank`

## Requirements
- R1: After the synchronous active-low reset, every pin has its driver off (`pin_oe` = 0), every output level is 0 (`pin_out` = 0) and `rd_data` reads 0.
- R2: A write with bit 2n of `wr_data` at 1 makes `pin_out[n]` 0 from the clock edge that captures the write.
- R3: A write with bit 2n+1 at 1 and bit 2n at 0 makes `pin_out[n]` 1 from the capturing edge.
- R4: A write with bit 2n+16 at 1 and bit 2n+17 at 0 makes `pin_oe[n]` 1 from the capturing edge.
- R5: A write with bit 2n+17 at 1 makes `pin_oe[n]` 0 from the capturing edge.
- R6: Bits written as 0 leave the matching state unchanged, and when `wr_en` is low the state is unchanged whatever `wr_data` holds.
- R7: When bits 2n and 2n+1 are both 1 in one write, the pin's output level becomes 0.
- R8: When bits 2n+16 and 2n+17 are both 1 in one write, the pin's driver turns off.
- R9: For a pin whose driver is on, `rd_data[2n+1]` equals `pin_out[n]`. This holds in the cycle right after the write that changed it.
- R10: For a pin whose driver is off, `rd_data[2n+1]` follows `pin_in[n]` through two flops. A change first shows after the second rising edge.
- R11: Every `rd_data` bit other than 2n+1 for an existing pin reads 0.
- R12: With `NUM_PINS` = 4, command bits 8 to 15 and 24 to 31 have no effect, and only pins 0 to 3 exist.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word, four request bits per pin |
| rd_data | output | 32 | Pin levels at odd positions 2n+1, zero elsewhere |
| pin_out | output | NUM_PINS | Output level per pin |
| pin_oe | output | NUM_PINS | Output driver enable per pin |
| pin_in | input | NUM_PINS | Pad level per pin, asynchronous |

## Verification
Two conflicting requests for one pin can arrive in the same write. Raise and lower can both be set, and so can drive and release. The stimulus table includes words that set both bits of a data pair and both bits of a direction pair. The output and readback in the following cycle are judged against the rule that the lowering or releasing request wins. A second collision is a pad change on an undriven pin while a neighbour is rewritten. It is judged by checking that the changed level appears only after the second edge, while the rewritten neighbour reads back at once.

// File: rtl/sc_gpio_pkg.sv
// Package: shared constants and the per-pin request type for the GPIO bank.
// Assumes a 32-bit command word with direction requests starting at bit 16.
package sc_gpio_pkg;
    localparam int REG_W    = 32;
    localparam int DIR_OFS  = 16;
    localparam int MAX_PINS = 8;

    // Requests decoded for one pin from one write.
    typedef struct packed {
        logic lower;    // drive level to 0
        logic raise;    // drive level to 1
        logic drive;    // enable output driver
        logic release_; // disable output driver
    } pin_req_t;
endpackage

// File: rtl/sc_gpio_decode.sv
// Module: splits a strobed command word into per-pin requests.
// Assumes NUM_PINS <= MAX_PINS so every request bit lies inside the word.
module sc_gpio_decode
    import sc_gpio_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                   wr_en,
    input  logic [REG_W-1:0]       wr_data,
    output pin_req_t [NUM_PINS-1:0] req
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int DBIT = 2 * i;
        localparam int CBIT = 2 * i + DIR_OFS;
        // Gate each request bit with the strobe.
        assign req[i].lower    = wr_en & wr_data[DBIT];
        assign req[i].raise    = wr_en & wr_data[DBIT+1];
        assign req[i].drive    = wr_en & wr_data[CBIT];
        assign req[i].release_ = wr_en & wr_data[CBIT+1];
    end
endmodule

// File: rtl/sc_gpio_pin_ctl.sv
// Module: output level and driver-enable state of a single pin.
// Assumes requests are already strobe-qualified; lowering and releasing win ties.
module sc_gpio_pin_ctl
    import sc_gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  pin_req_t req,
    output logic     level,
    output logic     oe
);
    // Update the output level; a lower request overrides a raise.
    always_ff @(posedge clk) begin
        if (!rst_n)           level <= 1'b0;
        else if (req.lower)   level <= 1'b0;
        else if (req.raise)   level <= 1'b1;
    end

    // Update the driver enable; a release request overrides a drive.
    always_ff @(posedge clk) begin
        if (!rst_n)              oe <= 1'b0;
        else if (req.release_)   oe <= 1'b0;
        else if (req.drive)      oe <= 1'b1;
    end
endmodule

// File: rtl/sc_gpio_sync.sv
// Module: two-flop synchronizer for asynchronous pad levels.
// Assumes each bit is independent; no multi-bit coherence is provided.
module sc_gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Shift pad levels through two registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/sc_gpio_bank.sv
// Module: top of the paired set/clear GPIO bank.
// Assumes 1 <= NUM_PINS <= 8; request bits of absent pins are ignored.
module sc_gpio_bank
    import sc_gpio_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [REG_W-1:0]    wr_data,
    output logic [REG_W-1:0]    rd_data,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    input  logic [NUM_PINS-1:0] pin_in
);
    pin_req_t [NUM_PINS-1:0] req;
    logic     [NUM_PINS-1:0] in_sync;

    sc_gpio_decode #(.NUM_PINS(NUM_PINS)) u_dec (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .req     (req)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        sc_gpio_pin_ctl u_ctl (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[i]),
            .level (pin_out[i]),
            .oe    (pin_oe[i])
        );
    end

    sc_gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (in_sync)
    );

    // Build the read word: driven pins show their own level, others the synchronized pad.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_PINS; i++) begin
            rd_data[2*i+1] = pin_oe[i] ? pin_out[i] : in_sync[i];
        end
    end
endmodule

// File: rtl/sc_gpio_chk.sv
// Module: assertion checker for sc_gpio_bank, attached by bind below.
// Assumes the same NUM_PINS as the instance it is bound to.
module sc_gpio_chk
    import sc_gpio_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [REG_W-1:0]    wr_data,
    input logic [REG_W-1:0]    rd_data,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe
);
    function automatic logic [REG_W-1:0] used_mask();
        logic [REG_W-1:0] m = '0;
        for (int i = 0; i < NUM_PINS; i++) m[2*i+1] = 1'b1;
        return m;
    endfunction
    localparam logic [REG_W-1:0] USED = used_mask();

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam int DB = 2 * i;
        localparam int CB = 2 * i + DIR_OFS;

        a_r2_lower: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[DB]) |=> !pin_out[i]);

        a_r3_raise: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[DB+1] && !wr_data[DB]) |=> pin_out[i]);

        a_r4_drive: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[CB] && !wr_data[CB+1]) |=> pin_oe[i]);

        a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[CB+1]) |=> !pin_oe[i]);

        a_r9_readback: assert property (@(posedge clk) disable iff (!rst_n)
            pin_oe[i] |-> (rd_data[DB+1] == pin_out[i]));
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r11_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED) == '0);
endmodule

bind sc_gpio_bank sc_gpio_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe)
);

// File: tb/sim_sc_gpio_bank.sv
// Bench: table-driven walk of the 8-pin bank, then directed reset, hold,
// synchronizer and 4-pin tests. Inputs change on the falling edge, outputs are sampled there too.
module sim_sc_gpio_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    typedef struct packed {
        logic [31:0] wd;
        logic [7:0]  out;
        logic [7:0]  oe;
    } vec_t;

    // Write word, expected output level, expected driver enable after the write.
    localparam vec_t VECS [NV] = '{
        '{32'h0000_0002, 8'h01, 8'h00},  // R3 pin0 raise
        '{32'h0001_0000, 8'h01, 8'h01},  // R4 pin0 drive
        '{32'h0000_AAAA, 8'hFF, 8'h01},  // R3 all raise
        '{32'h5555_0000, 8'hFF, 8'hFF},  // R4 all drive
        '{32'h0000_0003, 8'hFE, 8'hFF},  // R7 pin0 both data bits
        '{32'h000C_0000, 8'hFE, 8'hFD},  // R8 pin1 both dir bits
        '{32'h0000_0000, 8'hFE, 8'hFD},  // R6 empty write
        '{32'h0000_4000, 8'h7E, 8'hFD},  // R2 pin7 lower
        '{32'hA000_0000, 8'h7E, 8'h3D},  // R5 pin6 and pin7 release
        '{32'h0000_0010, 8'h7A, 8'h3D}   // R2 pin2 lower
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [7:0]  pin_in = '0;
    logic [31:0] rd_data, rd4;
    logic [7:0]  pin_out, pin_oe;
    logic [3:0]  out4, oe4;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_gpio_bank #(.NUM_PINS(8)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    sc_gpio_bank #(.NUM_PINS(4)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd4), .pin_out(out4), .pin_oe(oe4), .pin_in(pin_in[3:0])
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected read word from levels, enables and synchronized pad levels (R9, R10, R11).
    function automatic logic [31:0] rd_exp(input logic [7:0] o, input logic [7:0] e,
                                           input logic [7:0] pads, input int n);
        logic [31:0] r = '0;
        for (int i = 0; i < n; i++) r[2*i+1] = e[i] ? o[i] : pads[i];
        return r;
    endfunction

    task automatic do_write(input logic [31:0] w);
        wr_en = 1'b1;
        wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
        wr_data = '0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 oe", {24'h0, pin_oe}, 32'h0);
        chk("R1 out", {24'h0, pin_out}, 32'h0);
        chk("R1 rd", rd_data, 32'h0);

        for (int v = 0; v < NV; v++) begin
            do_write(VECS[v].wd);
            chk("R2-table out", {24'h0, pin_out}, {24'h0, VECS[v].out});
            chk("R4-table oe", {24'h0, pin_oe}, {24'h0, VECS[v].oe});
            chk("R9 rd", rd_data, rd_exp(VECS[v].out, VECS[v].oe, 8'h00, 8));
            chk("R11 unused", rd_data & 32'h5555_5555, 32'h0);
        end

        // R12: the 4-pin build tracks the low pins of the 8-pin build after the walk
        chk("R12 out4", {28'h0, out4}, {28'h0, VECS[NV-1].out[3:0]});
        chk("R12 oe4", {28'h0, oe4}, {28'h0, VECS[NV-1].oe[3:0]});

        // R6: data with strobe low changes nothing
        wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        wr_data = '0;
        chk("R6 out", {24'h0, pin_out}, 32'h7A);
        chk("R6 oe", {24'h0, pin_oe}, 32'h3D);

        // R10: pads rise; undriven pins 1, 6, 7 show it after the second edge only
        pin_in = 8'hFF;
        @(negedge clk);
        chk("R10 one edge", rd_data, rd_exp(8'h7A, 8'h3D, 8'h00, 8));
        @(negedge clk);
        chk("R10 two edges", rd_data, rd_exp(8'h7A, 8'h3D, 8'hFF, 8));
        chk("R11 4-pin rd", rd4 & 32'hFFFF_FF55, 32'h0);

        // R12: request bits of pins 4..7 only; 4-pin build ignores them
        do_write(32'hFF00_FF00);
        chk("R12 u0 out", {24'h0, pin_out}, 32'h0A);
        chk("R12 u0 oe", {24'h0, pin_oe}, 32'h0D);
        chk("R12 u1 out", {28'h0, out4}, 32'hA);
        chk("R12 u1 oe", {28'h0, oe4}, 32'hD);

        // R1: reset again from a busy state
        rst_n = 1'b0;
        pin_in = 8'h00;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 re-reset out", {24'h0, pin_out}, 32'h0);
        chk("R1 re-reset oe", {28'h0, oe4}, 32'h0);

        finish_run();
    end
endmodule